// File: doc/BRIEF.md
# Serial Microword Fetch Controller

This block drives a byte-wide microcode memory and turns its output into a 48-bit horizontal control word for a processor. It runs on a fast clock that is eight times the processor T-state rate. At the start of each T-state it samples the condition flags and the opcode. It then steps a 3-bit byte slot through one full cycle. During the first six slots it reads one byte of the current microword. When all six bytes are collected, it loads them into the control-line register in a single step.

The memory address joins the held flags, the held opcode, the running T-state count and the byte slot. Each flag combination therefore selects its own microcode region. Each instruction can have up to 32 T-states. The memory is treated as combinational: `rom_rdata` must reflect `rom_addr` within the same fast-clock cycle. The ROM port is a plain address/data pair and has no handshake. The memory is read every slot and cannot apply back-pressure.

Top module: `ucf_fetch_top`

## Requirements
- R1: `rom_addr` is {flags[2:0], opcode[7:0], T-state[4:0], slot[2:0]}, from most to least significant. The flags bit order is [2]=zero, [1]=carry, [0]=compare.
- R2: The slot advances by one on every fast clock and wraps from 7 to 0. The T-state field changes only on the clock edge where the slot wraps from 7 to 0, and it then increments by one.
- R3: The byte read in slot n (n = 0..5) appears on `ctrl_word[8n+7:8n]`.
- R4: Slots 6 and 7 are idle. Memory data presented during these slots never reaches `ctrl_word`.
- R5: `ctrl_word` changes only on the clock edge that leaves slot 6, and all 48 bits change together. From slot 0 through slot 6 of the following T-state, it holds the previous complete word.
- R6: `flags` and `opcode` are captured only on the 7-to-0 wrap edge. Changes to these inputs during slots 0 to 6 have no effect on `rom_addr` or on the word being assembled.
- R7: If `ts_restart` is high on the wrap edge, the next T-state is 0. At any other slot, `ts_restart` is ignored.
- R8: Without a restart, the T-state count wraps from 31 to 0.
- R9: A synchronous reset sets the slot, the T-state, the held flags and opcode, and `ctrl_word` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast fetch clock, 8 per T-state |
| rst | input | 1 | Synchronous active-high reset |
| flags | input | 3 | Zero, carry, compare condition bits |
| opcode | input | 8 | Current instruction opcode |
| ts_restart | input | 1 | Return the T-state count to 0 at the next boundary |
| rom_addr | output | 19 | Microcode memory byte address |
| rom_rdata | input | 8 | Byte returned by the microcode memory |
| ctrl_word | output | 48 | Assembled control-line word |

## Verification
A slot counter that drifts changes the low three address bits within one fast clock. It also moves bytes into the wrong lanes, or pulls in idle-slot data, and the corrupted word appears at the end of that T-state. A wrong held flag, opcode or T-state value shows in the upper address bits from slot 0 onward. A load of the output register on the wrong slot shows as a mid-T-state change of `ctrl_word`, or as a partially stale word, before the T-state ends.

// File: rtl/ucf_pkg.sv
package ucf_pkg;
  localparam int FLAG_W  = 3;
  localparam int OP_W    = 8;
  localparam int TS_W    = 5;
  localparam int SLOT_W  = 3;
  localparam int BYTES   = 6;
  localparam int BYTE_W  = 8;
endpackage

// File: rtl/ucf_sequencer.sv
module ucf_sequencer #(
  parameter int FLAG_W = ucf_pkg::FLAG_W,
  parameter int OP_W   = ucf_pkg::OP_W,
  parameter int TS_W   = ucf_pkg::TS_W,
  parameter int SLOT_W = ucf_pkg::SLOT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic              restart_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [TS_W-1:0]   tstate_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [OP_W-1:0]   opcode_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

  logic [SLOT_W-1:0] slot_q;
  logic [TS_W-1:0]   ts_q;
  logic [FLAG_W-1:0] flg_q;
  logic [OP_W-1:0]   op_q;
  logic              boundary;

  assign boundary = (slot_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      ts_q   <= '0;
      flg_q  <= '0;
      op_q   <= '0;
    end else begin
      slot_q <= slot_q + SLOT_W'(1);
      if (boundary) begin
        flg_q <= flags_i;
        op_q  <= opcode_i;
        ts_q  <= restart_i ? '0 : ts_q + TS_W'(1);
      end
    end
  end

  assign slot_o   = slot_q;
  assign tstate_o = ts_q;
  assign flags_o  = flg_q;
  assign opcode_o = op_q;

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> slot_q == SLOT_W'($past(slot_q) + SLOT_W'(1)));
  assert_ts_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (slot_q != LAST_SLOT) |=> $stable(ts_q));
  assert_inputs_held_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_q != LAST_SLOT) |=> ($stable(flg_q) && $stable(op_q)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (boundary && restart_i) |=> ts_q == '0);
  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (slot_q == '0 && ts_q == '0 && flg_q == '0 && op_q == '0));
endmodule

// File: rtl/ucf_assembler.sv
module ucf_assembler #(
  parameter int SLOT_W = ucf_pkg::SLOT_W,
  parameter int BYTES  = ucf_pkg::BYTES,
  parameter int BYTE_W = ucf_pkg::BYTE_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOT_W-1:0]       slot_i,
  input  logic [BYTE_W-1:0]       data_i,
  output logic [BYTES*BYTE_W-1:0] word_o
);
  localparam int                WORD_W    = BYTES * BYTE_W;
  localparam logic [SLOT_W-1:0] LOAD_SLOT = SLOT_W'(BYTES);

  logic [BYTES-1:0][BYTE_W-1:0] shadow_q;
  logic [WORD_W-1:0]            word_q;

  for (genvar n = 0; n < BYTES; n++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) shadow_q[n] <= '0;
      else if (slot_i == SLOT_W'(n)) shadow_q[n] <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (slot_i == LOAD_SLOT) word_q <= shadow_q;
  end

  assign word_o = word_q;

  assert_idle_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (slot_i >= LOAD_SLOT) |=> $stable(shadow_q));
  assert_atomic_word_R5: assert property (@(posedge clk) disable iff (rst)
    (slot_i != LOAD_SLOT) |=> $stable(word_q));
  assert_word_reset_R9: assert property (@(posedge clk)
    rst |=> word_q == '0);
endmodule

// File: rtl/ucf_fetch_top.sv
module ucf_fetch_top #(
  parameter int FLAG_W = ucf_pkg::FLAG_W,
  parameter int OP_W   = ucf_pkg::OP_W,
  parameter int TS_W   = ucf_pkg::TS_W,
  parameter int SLOT_W = ucf_pkg::SLOT_W,
  parameter int BYTES  = ucf_pkg::BYTES,
  parameter int BYTE_W = ucf_pkg::BYTE_W,
  localparam int ADDR_W = FLAG_W + OP_W + TS_W + SLOT_W,
  localparam int WORD_W = BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAG_W-1:0] flags,
  input  logic [OP_W-1:0]   opcode,
  input  logic              ts_restart,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0] rom_rdata,
  output logic [WORD_W-1:0] ctrl_word
);
  logic [SLOT_W-1:0] slot;
  logic [TS_W-1:0]   tstate;
  logic [FLAG_W-1:0] flg_held;
  logic [OP_W-1:0]   op_held;

  ucf_sequencer #(
    .FLAG_W(FLAG_W), .OP_W(OP_W), .TS_W(TS_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .flags_i(flags), .opcode_i(opcode),
    .restart_i(ts_restart), .slot_o(slot), .tstate_o(tstate),
    .flags_o(flg_held), .opcode_o(op_held)
  );

  assign rom_addr = {flg_held, op_held, tstate, slot};

  ucf_assembler #(
    .SLOT_W(SLOT_W), .BYTES(BYTES), .BYTE_W(BYTE_W)
  ) u_asm (
    .clk(clk), .rst(rst), .slot_i(slot), .data_i(rom_rdata),
    .word_o(ctrl_word)
  );

  initial assert_fit_R3: assert (BYTES < (1 << SLOT_W));
endmodule

// File: tb/ucf_fetch_top_bench.sv
module ucf_fetch_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  flags = '0;
  logic [7:0]  opcode = '0;
  logic        ts_restart = 1'b0;
  logic [18:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [47:0] ctrl_word;

  int checks = 0;
  int errors = 0;
  logic [4:0]  exp_t = '0;
  logic [47:0] prev_word = '0;

  always #5 clk = ~clk;

  ucf_fetch_top u_ucf_fetch_top (
    .clk(clk), .rst(rst), .flags(flags), .opcode(opcode),
    .ts_restart(ts_restart), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ctrl_word(ctrl_word)
  );

  function automatic logic [7:0] rom_byte(input logic [18:0] a);
    if (a[2:0] >= 3'd6) return 8'hEE;
    return (a[10:3] ^ a[18:11]) + {a[2:0], 5'd0} + 8'(a[2:0] * 8'd37) + 8'h11;
  endfunction

  assign rom_rdata = rom_byte(rom_addr);

  function automatic logic [47:0] word_of(input logic [2:0] f, input logic [7:0] op,
                                          input logic [4:0] t);
    logic [47:0] w;
    for (int n = 0; n < 6; n++) w[8*n +: 8] = rom_byte({f, op, t, 3'(n)});
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] f, input logic [7:0] op, input logic rs);
    logic [47:0] w;
    flags = f; opcode = op; ts_restart = rs;
    exp_t = rs ? 5'd0 : exp_t + 5'd1;
    w = word_of(f, op, exp_t);
    @(negedge clk);
    check("R2 slot 0 and T-state", 64'(rom_addr[7:0]), 64'({exp_t, 3'd0}));
    flags = ~f; opcode = ~op; ts_restart = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 R6 address layout with held inputs", 64'(rom_addr), 64'({f, op, exp_t, 3'd2}));
    @(negedge clk);
    check("R5 previous word held mid T-state", 64'(ctrl_word), 64'(prev_word));
    repeat (3) @(negedge clk);
    check("R5 previous word held at slot 6", 64'(ctrl_word), 64'(prev_word));
    ts_restart = 1'b0;
    @(negedge clk);
    check("R3 R4 assembled word", 64'(ctrl_word), 64'(w));
    prev_word = w;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  localparam logic [11:0] VEC [12] = '{
    {3'b000, 8'h00, 1'b0}, {3'b100, 8'h3C, 1'b0}, {3'b010, 8'hA5, 1'b0},
    {3'b001, 8'hFF, 1'b0}, {3'b111, 8'h01, 1'b1}, {3'b110, 8'h80, 1'b0},
    {3'b011, 8'h5A, 1'b0}, {3'b101, 8'h7E, 1'b1}, {3'b000, 8'hC3, 1'b0},
    {3'b111, 8'hFF, 1'b0}, {3'b001, 8'h10, 1'b1}, {3'b100, 8'h99, 1'b0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset address", 64'(rom_addr), 64'd0);
    check("R9 reset word", 64'(ctrl_word), 64'd0);
    repeat (7) @(negedge clk);
    check("R3 first word after reset", 64'(ctrl_word), 64'(word_of(3'd0, 8'd0, 5'd0)));
    prev_word = word_of(3'd0, 8'd0, 5'd0);
    exp_t = '0;

    for (int i = 0; i < 12; i++) step(VEC[i][11:9], VEC[i][8:1], VEC[i][0]);

    // R7: explicit restart, then R8 wrap of the T-state count
    step(3'b010, 8'h42, 1'b1);
    check("R7 restart gives T-state 0", 64'(exp_t), 64'd0);
    for (int i = 0; i < 31; i++) step(3'(i), 8'(i * 7), 1'b0);
    check("R8 reached T-state 31", 64'(rom_addr[7:3]), 64'd31);
    step(3'b101, 8'hE1, 1'b0);
    check("R8 wrap to T-state 0", 64'(rom_addr[7:3]), 64'd0);

    // R9: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-run reset word", 64'(ctrl_word), 64'd0);
    check("R9 mid-run reset address", 64'(rom_addr), 64'd0);
    flags = 3'b111; opcode = 8'hAA;
    rst = 1'b0;
    repeat (7) @(negedge clk);
    check("R9 word after reset uses cleared inputs", 64'(ctrl_word),
          64'(word_of(3'd0, 8'd0, 5'd0)));
    report();
  end
endmodule